// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Controller

This block copies a block of bytes from one region of memory to another without the processor's help. Software sets it up through a small 8-bit I/O port. It loads a 16-bit start address for each of two channels, one transfer count, a page value for the upper address bits, a command byte, a mask byte and a software request. Channel 0's address is the source and channel 1's address is the destination. Each 16-bit value goes in as two byte writes to one port. A shared byte-pointer flip-flop picks the half, and a separate port write puts the pointer back to the low byte.

Once started, the controller raises HOLD and waits for the host to answer with HLDA. The host answers in this way because it floats its buses while held. The controller then moves each byte in two bus cycles: a read into an internal temporary register, then a write of that register. HOLD stays high for the whole block. After the last write the controller drops HOLD and sets a terminal-count flag, which software polls through the status register. A fill option keeps the source address fixed, so that one byte is written across the whole destination block. This is how software clears or fills a memory area.

Top module: `dma_m2m_ctrl`

## Requirements
- R1: After reset, hold, mem_rd and mem_wr are 0, the status register (port 8) reads 0, all channels are masked, no request is pending and the byte pointer selects the low byte.
- R2: mem_rd and mem_wr are asserted only while both hold and hlda are 1. No bus cycle begins before hlda has been seen high.
- R3: A channel address (port 0 for channel 0, port 2 for channel 1) or the count (port 3) is written as a low byte then a high byte through one shared pointer. The pointer toggles on every write to any of those ports. A write to port 11 (any data) returns the pointer to the low byte.
- R4: When the count is loaded with N-1, exactly N bytes are written. Memory just outside the destination block is left unchanged.
- R5: Each byte is read at the channel 0 address and then written at the channel 1 address, with the byte just read. Both addresses advance by one per byte, carrying across 16 bits.
- R6: When command bit 1 is set together with bit 0 (command value 03h), the channel 0 address stays fixed. Every destination byte then receives the source byte, while the channel 1 address still advances.
- R7: A transfer starts only when command bit 0 is 1, channel 0's request bit is set and mask bit 0 is 0. A request write (port 9) sets or clears the request of the channel in data bits 1:0 according to data bit 2 (04h sets channel 0, 00h clears it). With command bit 0 at 0 no transfer starts.
- R8: A write to port 10 loads the mask: bit n set masks channel n. While channel 0 is masked, a pending request never raises hold.
- R9: After the final write, hold drops and status bit 0 (terminal count of channel 0) reads 1. Reading the status port clears the terminal-count bits, so the next read returns 0.
- R10: On terminal count, channel 0's request clears and mask bit 0 is set again. Unmasking afterwards therefore does not restart a transfer.
- R11: The page register (port 12, low PAGE_W data bits) drives the address bits above the 16-bit channel address on every bus cycle.
- R12: Once raised, hold stays high without a break until the last byte is written. For N bytes with hlda following hold by one cycle, hold is high for 2N+2 cycles in a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Register write strobe, one cycle per byte |
| io_rd | input | 1 | Register read strobe; a read of the status port clears the terminal-count bits |
| io_addr | input | 4 | Register port number |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data (status at port 8, zero elsewhere) |
| hold | output | 1 | Bus request to the host |
| hlda | input | 1 | Bus grant from the host |
| mem_addr | output | PAGE_W+16 | Bus address: page bits over the channel address |
| mem_rd | output | 1 | Memory read strobe; data is sampled at the end of the cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data from the temporary register |

## Verification
The bench builds the block with its defaults: two channels, 16-bit channel registers and a 4-bit page. The page value 3 makes a 20-bit bus address whose upper bits differ from zero, so any loss of the page bits shows on the address. The 16-bit width lets one vector cross from address 00FFh into 0100h, which exercises the carry between the two bytes loaded through the pointer. With two channels, the mask value 0Eh leaves a masked channel 1 beside the unmasked channel 0.

// File: rtl/dma_pkg.sv
package dma_pkg;

    // Register port numbers on the processor side
    localparam int IO_AW = 4;
    localparam logic [IO_AW-1:0] PORT_CNT    = 4'd3;
    localparam logic [IO_AW-1:0] PORT_CMD    = 4'd8;  // write: command, read: status
    localparam logic [IO_AW-1:0] PORT_REQ    = 4'd9;
    localparam logic [IO_AW-1:0] PORT_MASK   = 4'd10;
    localparam logic [IO_AW-1:0] PORT_CLRPTR = 4'd11;
    localparam logic [IO_AW-1:0] PORT_PAGE   = 4'd12;

    typedef struct packed {
        logic hold_src;   // bit 1: keep the source address fixed
        logic en_m2m;     // bit 0: memory-to-memory enable
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    // Port number of the address register of a channel
    function automatic logic [IO_AW-1:0] chan_addr_port(input int ch);
        return IO_AW'(2 * ch);
    endfunction

endpackage

// File: rtl/dma_chan_addr.sv
module dma_chan_addr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         ptr_hi,
    input  logic [7:0]   wdata,
    input  logic         advance,
    output logic [W-1:0] value
);

    logic [W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (wr_en) begin
            if (ptr_hi) value_q[W-1:8] <= wdata[W-9:0];
            else        value_q[7:0]   <= wdata;
        end else if (advance) begin
            value_q <= value_q + W'(1);
        end
    end

    assign value = value_q;

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              tc_set,
    output cmd_t              cmd,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] tc,
    output logic [PAGE_W-1:0] page,
    output logic [NUM_CH-1:0] addr_wr,
    output logic              cnt_wr,
    output logic              ptr_hi,
    output logic [7:0]        io_rdata
);

    logic ptr_q;
    logic any_wide_wr;
    cmd_t cmd_q;
    logic [NUM_CH-1:0] mask_q, req_q, tc_q;
    logic [NUM_CH-1:0] mask_d, req_d, tc_d;
    logic [PAGE_W-1:0] page_q;
    logic unused_bits;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_port
        assign addr_wr[c] = io_wr && (io_addr == chan_addr_port(c));
    end
    assign cnt_wr      = io_wr && (io_addr == PORT_CNT);
    assign any_wide_wr = (|addr_wr) || cnt_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= 1'b0;
        end else if (io_wr && io_addr == PORT_CLRPTR) begin
            ptr_q <= 1'b0;
        end else if (any_wide_wr) begin
            ptr_q <= ~ptr_q;
        end
    end

    always_comb begin
        mask_d = mask_q;
        req_d  = req_q;
        tc_d   = tc_q;
        if (io_wr && io_addr == PORT_MASK) mask_d = io_wdata[NUM_CH-1:0];
        if (io_wr && io_addr == PORT_REQ) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (io_wdata[1:0] == 2'(c)) req_d[c] = io_wdata[2];
            end
        end
        if (io_rd && io_addr == PORT_CMD) tc_d = '0;
        if (tc_set) begin
            mask_d[0] = 1'b1;
            req_d[0]  = 1'b0;
            tc_d[0]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            mask_q <= '1;
            req_q  <= '0;
            tc_q   <= '0;
            page_q <= '0;
        end else begin
            mask_q <= mask_d;
            req_q  <= req_d;
            tc_q   <= tc_d;
            if (io_wr && io_addr == PORT_CMD)  cmd_q  <= cmd_t'(io_wdata[1:0]);
            if (io_wr && io_addr == PORT_PAGE) page_q <= io_wdata[PAGE_W-1:0];
        end
    end

    assign io_rdata    = (io_addr == PORT_CMD) ? {{(8-NUM_CH){1'b0}}, tc_q} : 8'h00;
    assign cmd         = cmd_q;
    assign mask        = mask_q;
    assign req         = req_q;
    assign tc          = tc_q;
    assign page        = page_q;
    assign ptr_hi      = ptr_q;
    assign unused_bits = ^io_wdata;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       hlda,
    input  logic       last,
    input  logic [7:0] rd_data,
    output logic       hold,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic       finish,
    output logic [7:0] temp
);

    seq_state_e state_q, state_d;
    logic [7:0] temp_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_REQUEST;
            ST_REQUEST: if (hlda)  state_d = ST_READ;
            ST_READ:    if (hlda)  state_d = ST_WRITE;
            ST_WRITE:   if (hlda)  state_d = last ? ST_DONE : ST_READ;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            temp_q  <= '0;
        end else begin
            state_q <= state_d;
            if (bus_rd) temp_q <= rd_data;
        end
    end

    assign hold   = (state_q == ST_REQUEST) || (state_q == ST_READ) || (state_q == ST_WRITE);
    assign bus_rd = (state_q == ST_READ)  && hlda;
    assign bus_wr = (state_q == ST_WRITE) && hlda;
    assign finish = bus_wr && last;
    assign temp   = temp_q;

endmodule

// File: rtl/dma_m2m_ctrl.sv
module dma_m2m_ctrl
    import dma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 16,
    parameter int PAGE_W = 4,
    localparam int ADDR_W = PAGE_W + CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              hold,
    input  logic              hlda,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata
);

    cmd_t              cmd;
    logic [NUM_CH-1:0] mask_vec, req_vec, tc_vec, addr_wr;
    logic [PAGE_W-1:0] page;
    logic              cnt_wr, ptr_hi, start, finish, bus_rd, bus_wr;
    logic [CH_W-1:0]   chan_addr [NUM_CH];
    logic [CH_W-1:0]   count_q;
    logic [7:0]        temp;
    logic              unused_bits;

    dma_ctl_regs #(.NUM_CH(NUM_CH), .PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .tc_set(finish), .cmd(cmd), .mask(mask_vec),
        .req(req_vec), .tc(tc_vec), .page(page), .addr_wr(addr_wr),
        .cnt_wr(cnt_wr), .ptr_hi(ptr_hi), .io_rdata(io_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic adv;
        if (c == 0) begin : g_src
            assign adv = bus_wr && !cmd.hold_src;
        end else if (c == 1) begin : g_dst
            assign adv = bus_wr;
        end else begin : g_spare
            assign adv = 1'b0;
        end
        dma_chan_addr #(.W(CH_W)) u_addr (
            .clk(clk), .rst(rst), .wr_en(addr_wr[c]), .ptr_hi(ptr_hi),
            .wdata(io_wdata), .advance(adv), .value(chan_addr[c])
        );
    end

    // Transfer count: loaded with bytes minus one, ends when it wraps below zero
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            if (ptr_hi) count_q[CH_W-1:8] <= io_wdata[CH_W-9:0];
            else        count_q[7:0]      <= io_wdata;
        end else if (bus_wr) begin
            count_q <= count_q - CH_W'(1);
        end
    end

    assign start = cmd.en_m2m && req_vec[0] && !mask_vec[0];

    dma_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .hlda(hlda),
        .last(count_q == '0), .rd_data(mem_rdata), .hold(hold),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .finish(finish), .temp(temp)
    );

    assign mem_rd    = bus_rd;
    assign mem_wr    = bus_wr;
    assign mem_wdata = bus_wr ? temp : 8'h00;
    assign mem_addr  = bus_rd ? {page, chan_addr[0]} :
                       bus_wr ? {page, chan_addr[1]} : '0;

    assign unused_bits = ^{mask_vec, req_vec};

endmodule

// File: rtl/dma_m2m_checker.sv
module dma_m2m_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              hlda,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [NUM_CH-1:0] tc_vec,
    input logic [NUM_CH-1:0] mask_vec,
    input logic [NUM_CH-1:0] req_vec
);

    assert_bus_needs_grant_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (hold && hlda));

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_wr) && $past(hlda)) |-> $past(mem_rd));

    assert_masked_no_start_R8: assert property (@(posedge clk) disable iff (rst)
        (!hold && mask_vec[0]) |=> !hold);

    assert_tc_drops_hold_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_vec[0]) |-> !hold);

    assert_hold_continuous_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> tc_vec[0]);

    assert_tc_rearms_mask_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_vec[0]) |-> (mask_vec[0] && !req_vec[0]));

endmodule

bind dma_m2m_ctrl dma_m2m_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .hold(hold), .hlda(hlda), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .tc_vec(tc_vec), .mask_vec(mask_vec), .req_vec(req_vec)
);

// File: tb/tb_dma_m2m_ctrl.sv
module tb_dma_m2m_ctrl;

    localparam logic [3:0] PAGE = 4'h3;

    logic clk = 1'b0, rst = 1'b1;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic hold, hlda, mem_rd, mem_wr;
    logic [19:0] mem_addr;
    logic [7:0] mem_rdata, mem_wdata;

    int checks = 0, errors = 0;

    dma_m2m_ctrl dut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hold(hold), .hlda(hlda),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    always #5 clk = ~clk;

    // Host: grants one cycle after the request
    always @(posedge clk) hlda <= rst ? 1'b0 : hold;

    // Memory model, low 12 address bits
    logic [7:0] mem [0:4095];
    logic [7:0] shadow [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

    // Bus monitor
    int hold_cyc, hold_rises, no_grant, bad_page;
    logic prev_hold = 1'b0, seen_rd;
    logic [19:0] first_rd;
    always @(negedge clk) begin
        if (hold) hold_cyc++;
        if (hold && !prev_hold) hold_rises++;
        prev_hold = hold;
        if (mem_rd || mem_wr) begin
            if (!hlda) no_grant++;
            if (mem_addr[19:16] != PAGE) bad_page++;
        end
        if (mem_rd && !seen_rd) begin
            first_rd = mem_addr;
            seen_rd  = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic clear_mon();
        hold_cyc = 0; hold_rises = 0; no_grant = 0; bad_page = 0;
        seen_rd = 1'b0; first_rd = '0;
    endtask

    task automatic run_xfer(input logic [15:0] src, input logic [15:0] dst,
                            input int len, input bit fill);
        logic [7:0] st;
        logic [15:0] cnt;
        int miss, wait_cyc;
        cnt = 16'(len - 1);
        io_write(4'd11, 8'h00);
        io_write(4'd0, src[7:0]);  io_write(4'd0, src[15:8]);
        io_write(4'd2, dst[7:0]);  io_write(4'd2, dst[15:8]);
        io_write(4'd3, cnt[7:0]);  io_write(4'd3, cnt[15:8]);
        io_write(4'd12, {4'h0, PAGE});
        io_write(4'd8, fill ? 8'h03 : 8'h01);
        io_write(4'd10, 8'h0E);
        clear_mon();
        io_write(4'd9, 8'h04);
        wait_cyc = 0;
        while (!(hold_rises > 0 && !hold) && wait_cyc < 2000) begin
            @(negedge clk); wait_cyc++;
        end
        repeat (3) @(negedge clk);
        // Expected image
        for (int i = 0; i < len; i++)
            shadow[12'(dst + 16'(i))] = fill ? shadow[src[11:0]] : shadow[12'(src + 16'(i))];
        miss = 0;
        for (int i = -1; i <= len; i++)
            if (mem[12'(int'(dst) + i)] != shadow[12'(int'(dst) + i)]) miss++;
        check(miss == 0, fill ? "R6 fill contents" : "R4/R5 copy contents and guards", miss, 0);
        check(first_rd == {PAGE, src}, "R3/R5 first source address", first_rd, {PAGE, src});
        check(hold_rises == 1 && hold_cyc == 2 * len + 2, "R12 hold pulse length",
              hold_cyc, 2 * len + 2);
        check(no_grant == 0, "R2 strobe without grant", no_grant, 0);
        check(bad_page == 0, "R11 page bits", bad_page, 0);
        io_read(4'd8, st);
        check(st == 8'h01, "R9 terminal count flag", st, 8'h01);
        io_read(4'd8, st);
        check(st == 8'h00, "R9 status cleared by read", st, 8'h00);
    endtask

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] len;
        logic        fill;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'h0010, 16'h0200, 16'd1,  1'b0},
        '{16'h0020, 16'h0300, 16'd16, 1'b0},
        '{16'h00F8, 16'h01F0, 16'd20, 1'b0},
        '{16'h0040, 16'h0500, 16'd12, 1'b1},
        '{16'h0080, 16'h0580, 16'd3,  1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] st;
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!hold && !mem_rd && !mem_wr, "R1 bus idle after reset",
              {hold, mem_rd, mem_wr}, 0);
        io_read(4'd8, st);
        check(st == 8'h00, "R1 status after reset", st, 0);
        // R8: channels masked after reset, request must not start
        io_write(4'd8, 8'h01);
        clear_mon();
        io_write(4'd9, 8'h04);
        repeat (10) @(negedge clk);
        check(hold_rises == 0, "R8 masked channel held off", hold_rises, 0);
        io_write(4'd9, 8'h00);
        // R7: memory-to-memory disabled
        io_write(4'd8, 8'h00);
        io_write(4'd10, 8'h0E);
        clear_mon();
        io_write(4'd9, 8'h04);
        repeat (10) @(negedge clk);
        check(hold_rises == 0, "R7 no start with command bit 0 clear", hold_rises, 0);
        // R7: cleared request does not start once enabled
        io_write(4'd9, 8'h00);
        io_write(4'd8, 8'h01);
        repeat (10) @(negedge clk);
        check(hold_rises == 0, "R7 request clear write", hold_rises, 0);
        io_write(4'd10, 8'h0F);

        foreach (VECS[k]) run_xfer(VECS[k].src, VECS[k].dst, int'(VECS[k].len), VECS[k].fill);

        // R10: after terminal count, unmasking does not restart
        clear_mon();
        io_write(4'd10, 8'h0E);
        repeat (10) @(negedge clk);
        check(hold_rises == 0, "R10 request cleared at terminal count", hold_rises, 0);
        io_write(4'd10, 8'h0F);
        io_write(4'd9, 8'h04);
        repeat (10) @(negedge clk);
        check(hold_rises == 0, "R8 masked again after request", hold_rises, 0);
        io_write(4'd9, 8'h00);

        // R3: stray byte moves the pointer; the clear port resets it
        io_write(4'd0, 8'h99);
        run_xfer(16'h0600, 16'h0700, 2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule